// File: doc/BRIEF.md
# Flash command interface with erase suspend

This block is a behavioural model of a NOR-style flash device as its host sees it. A host issues single-cycle bus writes that carry a command code, or the address and data of a pending operation. The block decodes them and runs word programs and block erases as timed busy operations over a small internal array. It keeps sticky error bits in a status register and reports readiness on a ready/busy line that can drive low, drive high or float.

A block erase can be suspended partway through. While it is suspended the host may read the array or program a word in a different block. The erase then resumes from the cycle count it had left. A resume written while a suspend-time program is still running is held back until that program finishes.

Reads are combinational. A mode bit selects whether `rd_data` shows the addressed array word or the status byte. The programming-voltage flag and the two protect inputs are plain digital levels. They are sampled when the address and data write of an operation is accepted.

Top module: `flash_cmd_top`

## Requirements
- R1: A program is a setup write of 40h or 10h followed by a write of address and data. The word becomes the old word AND the data, so a program can only clear bits.
- R2: After a program data write, an erase confirm, a suspend or a resume, and after 70h, every read returns the status byte whatever the address, until FFh selects array reads.
- R3: Status bit 7 is 1 when ready and 0 when busy. While busy, `rdy_oe`=1 and `rdy_o`=0. A program stays busy for exactly PROG_CYC+1 cycles after its data write.
- R4: Asking for a 1 over a stored 0 raises no error: status bit 4 stays 0 and the stored 0 is kept.
- R5: A program accepted while `vpp_ok`=0 sets status bits 3 and 4 and leaves the array unchanged. An erase accepted while `vpp_ok`=0 sets bits 3 and 5.
- R6: A program to block BOOT_BLK (address bits [ADDR_W-1 -: BLK_W]) with `wp_n`=0 and `rp_hv`=0 sets status bits 1 and 4 and is blocked. With `wp_n`=1, or with `rp_hv`=1, it proceeds.
- R7: A block erase is 20h followed by D0h at an address in the block. It sets every word of that block to all ones, leaves other blocks alone, and spends exactly ERASE_CYC+1 cycles in running-erase states. Any other second write abandons the erase.
- R8: B0h during an erase suspends it. SUSP_LAT+1 cycles after the B0h write the status byte reads C0h (bits 7 and 6 set) and `rdy_oe`=0.
- R9: While suspended, only FFh, 70h, 40h/10h and D0h act. Other codes, such as 50h and 20h, change neither the status byte nor the suspended state.
- R10: A program issued while suspended shows status bits 7:6 = 01 with `rdy_oe`=1 and `rdy_o`=0 for PROG_CYC+1 cycles. If it targets the suspended block, it is rejected with status bit 4.
- R11: D0h while suspended clears bits 6 and 7, drives `rdy_o` low and continues the erase from its remaining count. The total running-erase time stays ERASE_CYC+1 cycles.
- R12: A D0h written while a suspend-time program runs, including in its completion cycle, takes effect only once that program has finished. The erase then continues.
- R13: 50h when not suspended clears status bits 5, 4, 3 and 1.
- R14: If the erase count runs out before the suspend latency expires, the erase completes and the block is never suspended: bit 6 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | DATA_W | Write data; the low byte carries command codes |
| rd_data | output | DATA_W | Array word or status byte, depending on read mode |
| vpp_ok | input | 1 | Programming voltage present (0 = lockout) |
| wp_n | input | 1 | Write-protect pin level (0 = protect boot block) |
| rp_hv | input | 1 | Reset pin at its high-voltage level (overrides protect) |
| rdy_o | output | 1 | Ready/busy level (1 = ready) |
| rdy_oe | output | 1 | Ready/busy drive enable (0 = high impedance) |

## Verification
Two pairs of events can fall in the same cycle. A resume write can coincide with the completion of a program issued during the suspend, and the end of the suspend latency can coincide with the end of the erase count. The bench sweeps the resume write across every cycle offset from the start of the suspend-time program to past its end. It also sweeps the suspend write across every cycle of the erase. The verdict comes from cycle counts taken off the status byte: cycles of running erase must total ERASE_CYC+1, program-during-suspend must last PROG_CYC+1, and whether a suspend takes hold must match the arithmetic of offset, latency and erase length. The final array contents are checked as well.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,     // ready, no operation
        S_PSET,     // program setup received
        S_ESET,     // erase setup received
        S_PBUSY,    // program running
        S_EBUSY,    // erase running
        S_SPEND,    // erase running, suspend requested
        S_SUSP,     // erase suspended
        S_SPSET,    // program setup while suspended
        S_SPBUSY    // program running while suspended
    } fsm_e;

    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLEAR       = 8'h50;
    localparam logic [7:0] CMD_PROG        = 8'h40;
    localparam logic [7:0] CMD_PROG_ALT    = 8'h10;
    localparam logic [7:0] CMD_ERASE       = 8'h20;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

    // sticky error masks, bit positions of the status byte
    localparam logic [5:0] ERR_PROG_VPP   = 6'b01_1000; // bits 4,3
    localparam logic [5:0] ERR_PROG_PROT  = 6'b01_0010; // bits 4,1
    localparam logic [5:0] ERR_PROG_BLK   = 6'b01_0000; // bit 4
    localparam logic [5:0] ERR_ERASE_VPP  = 6'b10_1000; // bits 5,3
    localparam logic [5:0] ERR_ERASE_PROT = 6'b10_0010; // bits 5,1

endpackage

// File: rtl/flash_countdown.sv
module flash_countdown #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int BLK_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_en,
    input  logic [BLK_W-1:0]  erase_blk
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [ADDR_W-1:0] ia;
            ia = ADDR_W'(i);
            mem_d[i] = mem_q[i];
            if (erase_en && ia[ADDR_W-1 -: BLK_W] == erase_blk)
                mem_d[i] = '1;
            if (prog_en && ia == prog_addr)
                mem_d[i] = mem_q[i] & prog_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '1;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rd_word = mem_q[rd_addr];

    // programmed word must hold a 0 wherever the data asked for one
    logic [ADDR_W-1:0] chk_addr_q;
    logic [DATA_W-1:0] chk_data_q;
    always_ff @(posedge clk) begin
        chk_addr_q <= prog_addr;
        chk_data_q <= prog_data;
    end

    p_and_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en && !erase_en |=> (mem_q[chk_addr_q] & ~chk_data_q) == '0);

endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int BLK_W     = 2,
    parameter int BOOT_BLK  = 0,
    parameter int CNT_W     = 16,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 24,
    parameter int SUSP_LAT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic              vpp_ok,
    input  logic              wp_n,
    input  logic              rp_hv,
    output logic              rdy_o,
    output logic              rdy_oe
);

    localparam logic [BLK_W-1:0] BOOT    = BLK_W'(BOOT_BLK);
    localparam logic [CNT_W-1:0] P_LOAD  = CNT_W'(PROG_CYC);
    localparam logic [CNT_W-1:0] E_LOAD  = CNT_W'(ERASE_CYC);
    localparam logic [CNT_W-1:0] L_LOAD  = CNT_W'(SUSP_LAT);

    typedef struct packed {
        fsm_e              st;
        logic              sts_mode;  // 1: reads return status
        logic [5:0]        err;       // sticky status bits 5..0
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
        logic [5:0]        pmask;     // error to post when program ends
        logic [BLK_W-1:0]  eblk;
        logic [5:0]        emask;     // error to post when erase ends
        logic              res_pend;  // resume seen during suspend program
    } ctl_t;

    ctl_t r_q, r_d;

    logic [7:0]        cmd;
    logic [BLK_W-1:0]  wr_blk;
    logic              prot_hit;
    logic              prog_load, erase_load, lat_load;
    logic              prog_run, erase_run, lat_run;
    logic [CNT_W-1:0]  prog_cnt, erase_cnt, lat_cnt;
    logic              prog_zero, erase_zero, lat_zero;
    logic              arr_prog, arr_erase;
    logic [DATA_W-1:0] arr_word;
    logic              ready, susp;
    logic [7:0]        sts;

    assign cmd      = wdata[7:0];
    assign wr_blk   = addr[ADDR_W-1 -: BLK_W];
    assign prot_hit = (wr_blk == BOOT) && !wp_n && !rp_hv;

    assign prog_run  = (r_q.st == S_PBUSY) || (r_q.st == S_SPBUSY);
    assign erase_run = (r_q.st == S_EBUSY) || (r_q.st == S_SPEND);
    assign lat_run   = (r_q.st == S_SPEND);

    assign prog_zero  = (prog_cnt == '0);
    assign erase_zero = (erase_cnt == '0);
    assign lat_zero   = (lat_cnt == '0);

    function automatic logic [5:0] prog_fail(input logic vpp, input logic prot);
        if (!vpp)     return ERR_PROG_VPP;
        else if (prot) return ERR_PROG_PROT;
        else           return 6'b0;
    endfunction

    function automatic logic [5:0] erase_fail(input logic vpp, input logic prot);
        if (!vpp)     return ERR_ERASE_VPP;
        else if (prot) return ERR_ERASE_PROT;
        else           return 6'b0;
    endfunction

    always_comb begin
        r_d        = r_q;
        prog_load  = 1'b0;
        erase_load = 1'b0;
        lat_load   = 1'b0;
        unique case (r_q.st)
            S_IDLE: if (wr_en) begin
                case (cmd)
                    CMD_READ_ARRAY:        r_d.sts_mode = 1'b0;
                    CMD_READ_STATUS:       r_d.sts_mode = 1'b1;
                    CMD_CLEAR:             r_d.err      = '0;
                    CMD_PROG, CMD_PROG_ALT: r_d.st      = S_PSET;
                    CMD_ERASE:             r_d.st       = S_ESET;
                    default: ;
                endcase
            end
            S_PSET: if (wr_en) begin
                r_d.paddr    = addr;
                r_d.pdata    = wdata;
                r_d.pmask    = prog_fail(vpp_ok, prot_hit);
                r_d.sts_mode = 1'b1;
                r_d.st       = S_PBUSY;
                prog_load    = 1'b1;
            end
            S_ESET: if (wr_en) begin
                if (cmd == CMD_CONFIRM) begin
                    r_d.eblk     = wr_blk;
                    r_d.emask    = erase_fail(vpp_ok, prot_hit);
                    r_d.sts_mode = 1'b1;
                    r_d.st       = S_EBUSY;
                    erase_load   = 1'b1;
                end else begin
                    r_d.st = S_IDLE;
                end
            end
            S_PBUSY: if (prog_zero) begin
                r_d.err = r_q.err | r_q.pmask;
                r_d.st  = S_IDLE;
            end
            S_EBUSY: begin
                if (erase_zero) begin
                    r_d.err = r_q.err | r_q.emask;
                    r_d.st  = S_IDLE;
                end else if (wr_en && cmd == CMD_SUSPEND) begin
                    r_d.sts_mode = 1'b1;
                    r_d.st       = S_SPEND;
                    lat_load     = 1'b1;
                end
            end
            S_SPEND: begin
                if (erase_zero) begin
                    r_d.err = r_q.err | r_q.emask;
                    r_d.st  = S_IDLE;
                end else if (lat_zero) begin
                    r_d.st = S_SUSP;
                end
            end
            S_SUSP: if (wr_en) begin
                case (cmd)
                    CMD_READ_ARRAY:         r_d.sts_mode = 1'b0;
                    CMD_READ_STATUS:        r_d.sts_mode = 1'b1;
                    CMD_PROG, CMD_PROG_ALT: r_d.st       = S_SPSET;
                    CMD_CONFIRM: begin
                        r_d.sts_mode = 1'b1;
                        r_d.st       = S_EBUSY;
                    end
                    default: ;
                endcase
            end
            S_SPSET: if (wr_en) begin
                r_d.paddr    = addr;
                r_d.pdata    = wdata;
                r_d.pmask    = prog_fail(vpp_ok, prot_hit) |
                               ((wr_blk == r_q.eblk) ? ERR_PROG_BLK : 6'b0);
                r_d.sts_mode = 1'b1;
                r_d.res_pend = 1'b0;
                r_d.st       = S_SPBUSY;
                prog_load    = 1'b1;
            end
            S_SPBUSY: begin
                r_d.res_pend = r_q.res_pend || (wr_en && cmd == CMD_CONFIRM);
                if (prog_zero) begin
                    r_d.err      = r_q.err | r_q.pmask;
                    r_d.st       = r_d.res_pend ? S_EBUSY : S_SUSP;
                    r_d.res_pend = 1'b0;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, sts_mode: 1'b0, err: '0, paddr: '0, pdata: '0,
                     pmask: '0, eblk: '0, emask: '0, res_pend: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    flash_countdown #(.CNT_W(CNT_W)) i_prog_tmr (
        .clk(clk), .rst_n(rst_n), .load(prog_load), .load_val(P_LOAD),
        .run(prog_run), .cnt(prog_cnt));

    flash_countdown #(.CNT_W(CNT_W)) i_erase_tmr (
        .clk(clk), .rst_n(rst_n), .load(erase_load), .load_val(E_LOAD),
        .run(erase_run), .cnt(erase_cnt));

    flash_countdown #(.CNT_W(CNT_W)) i_lat_tmr (
        .clk(clk), .rst_n(rst_n), .load(lat_load), .load_val(L_LOAD),
        .run(lat_run), .cnt(lat_cnt));

    assign arr_prog  = prog_run && prog_zero && (r_q.pmask == '0);
    assign arr_erase = erase_run && erase_zero && (r_q.emask == '0);

    flash_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) i_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_word(arr_word),
        .prog_en(arr_prog), .prog_addr(r_q.paddr), .prog_data(r_q.pdata),
        .erase_en(arr_erase), .erase_blk(r_q.eblk));

    assign ready = (r_q.st == S_IDLE) || (r_q.st == S_PSET) || (r_q.st == S_ESET) ||
                   (r_q.st == S_SUSP) || (r_q.st == S_SPSET);
    assign susp  = (r_q.st == S_SUSP) || (r_q.st == S_SPSET) || (r_q.st == S_SPBUSY);
    assign sts   = {ready, susp, r_q.err};

    assign rd_data = r_q.sts_mode ? DATA_W'(sts) : arr_word;
    assign rdy_o   = ready;
    assign rdy_oe  = !((r_q.st == S_SUSP) || (r_q.st == S_SPSET));

    p_busy_drives_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sts[7] |-> (rdy_oe && !rdy_o));

    p_lock_no_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_PSET && wr_en && !vpp_ok) |=> ##[0:0] (r_q.pmask[3] && r_q.pmask[4]));

    p_susp_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_SPEND && !erase_zero && lat_zero) |=> (r_q.st == S_SUSP && !rdy_oe));

    p_erase_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_SUSP || r_q.st == S_SPSET || r_q.st == S_SPBUSY) |=> $stable(erase_cnt));

    p_resume_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_SPBUSY && !prog_zero) |=> (r_q.st != S_EBUSY));

    p_race_done_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_SPEND && erase_zero) |=> (r_q.st == S_IDLE));

endmodule

// File: tb/test_flash_cmd_top.sv
`timescale 1ns/1ps
module test_flash_cmd_top;

    localparam int AW = 6;
    localparam int DW = 8;
    localparam int P  = 4;
    localparam int E  = 24;
    localparam int L  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_data;
    logic          vpp_ok = 1'b1;
    logic          wp_n = 1'b1;
    logic          rp_hv = 1'b0;
    logic          rdy_o, rdy_oe;

    int n_tests = 0;
    int n_fail  = 0;
    int run_n   = 0;
    int sp_n    = 0;
    bit mon_en  = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_top #(
        .ADDR_W(AW), .DATA_W(DW), .BLK_W(2), .BOOT_BLK(0), .CNT_W(16),
        .PROG_CYC(P), .ERASE_CYC(E), .SUSP_LAT(L)
    ) i_flash_cmd_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .vpp_ok(vpp_ok), .wp_n(wp_n), .rp_hv(rp_hv),
        .rdy_o(rdy_o), .rdy_oe(rdy_oe));

    // status-byte monitor: 00 in bits 7:6 = running erase, 01 = suspend program
    always @(negedge clk) begin
        if (mon_en) begin
            if (rd_data[7:6] == 2'b00) run_n++;
            if (rd_data[7:6] == 2'b01) sp_n++;
        end
    end

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not finish, act=hung exp=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        mon_en = 1'b0;
        vpp_ok = 1'b1; wp_n = 1'b1; rp_hv = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // counts cycles with status bit 7 low, starting at the current negedge
    task automatic wait_ready(output int cyc);
        cyc = 0;
        while (!rd_data[7]) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic rd_arr(input logic [AW-1:0] a, output logic [7:0] v);
        wr(0, 8'hFF);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d,
                        input logic [7:0] setup, output int cyc);
        wr(a, setup);
        wr(a, d);
        wait_ready(cyc);
    endtask

    initial begin
        int c;
        logic [7:0] v;

        // ---- reset state
        do_reset();
        addr = 6'h00; #1;
        chk(rd_data == 8'hFF, "R2 reset array read", rd_data, 8'hFF);
        chk(rdy_o && rdy_oe, "R3 reset ready line", {rdy_oe, rdy_o}, 2'b11);
        wr(0, 8'h70); #1;
        chk(rd_data == 8'h80, "R2 reset status", rd_data, 8'h80);

        // ---- program with both setup codes, busy length
        prog(6'h11, 8'hA5, 8'h40, c);
        chk(c == P + 1, "R3 program busy cycles", c, P + 1);
        addr = 6'h3F; #1;
        chk(rd_data == 8'h80, "R2 status shown after program", rd_data, 8'h80);
        rd_arr(6'h11, v);
        chk(v == 8'hA5, "R1 program 40h", v, 8'hA5);
        prog(6'h11, 8'h0F, 8'h10, c);
        rd_arr(6'h11, v);
        chk(v == 8'h05, "R1 program 10h ANDs", v, 8'h05);

        // ---- 1 over 0 is not an error
        prog(6'h11, 8'hFF, 8'h40, c);
        chk(rd_data == 8'h80, "R4 no error on 1 over 0", rd_data, 8'h80);
        rd_arr(6'h11, v);
        chk(v == 8'h05, "R4 stored zeros kept", v, 8'h05);

        // ---- voltage lockout, clear status
        vpp_ok = 1'b0;
        prog(6'h12, 8'h00, 8'h40, c);
        chk(rd_data == 8'h98, "R5 lockout status", rd_data, 8'h98);
        vpp_ok = 1'b1;
        rd_arr(6'h12, v);
        chk(v == 8'hFF, "R5 lockout array unchanged", v, 8'hFF);
        wr(0, 8'h50); wr(0, 8'h70); #1;
        chk(rd_data == 8'h80, "R13 clear status", rd_data, 8'h80);

        // ---- boot block protection
        wp_n = 1'b0; rp_hv = 1'b0;
        prog(6'h05, 8'h00, 8'h40, c);
        chk(rd_data == 8'h92, "R6 boot protect status", rd_data, 8'h92);
        rd_arr(6'h05, v);
        chk(v == 8'hFF, "R6 boot protect blocked", v, 8'hFF);
        wr(0, 8'h50);
        rp_hv = 1'b1;
        prog(6'h05, 8'h3C, 8'h40, c);
        chk(rd_data == 8'h80, "R6 high-voltage reset overrides", rd_data, 8'h80);
        rp_hv = 1'b0; wp_n = 1'b1;
        prog(6'h06, 8'hC3, 8'h40, c);
        rd_arr(6'h05, v);
        chk(v == 8'h3C, "R6 boot write with rp high", v, 8'h3C);
        rd_arr(6'h06, v);
        chk(v == 8'hC3, "R6 boot write with wp high", v, 8'hC3);

        // ---- erase setup abandoned by a wrong second write
        wr(6'h05, 8'h20); wr(6'h05, 8'h70); #1;
        chk(rd_data == 8'h3C && rdy_o, "R7 abandoned erase", rd_data, 8'h3C);

        // ---- plain erase of block 0 and lockout erase
        mon_en = 1'b0; run_n = 0;
        wr(6'h00, 8'h20);
        mon_en = 1'b1;
        wr(6'h00, 8'hD0);
        wait_ready(c);
        mon_en = 1'b0;
        chk(run_n == E + 1, "R7 erase busy cycles", run_n, E + 1);
        rd_arr(6'h05, v);
        chk(v == 8'hFF, "R7 block erased", v, 8'hFF);
        rd_arr(6'h11, v);
        chk(v == 8'h05, "R7 other block kept", v, 8'h05);
        vpp_ok = 1'b0;
        wr(6'h10, 8'h20); wr(6'h10, 8'hD0);
        wait_ready(c);
        chk(rd_data == 8'hA8, "R5 erase lockout status", rd_data, 8'hA8);
        vpp_ok = 1'b1;

        // ---- ignored commands while suspended
        do_reset();
        vpp_ok = 1'b0;
        prog(6'h30, 8'h00, 8'h40, c);
        vpp_ok = 1'b1;
        wr(6'h20, 8'h20); wr(6'h20, 8'hD0);
        wr(6'h20, 8'hB0);
        wait_ready(c);
        chk(rd_data == 8'hD8, "R9 suspended with errors", rd_data, 8'hD8);
        wr(0, 8'h50); #1;
        chk(rd_data == 8'hD8, "R9 clear ignored in suspend", rd_data, 8'hD8);
        wr(0, 8'h20); wr(0, 8'h70); #1;
        chk(rd_data == 8'hD8 && !rdy_oe, "R9 erase code ignored in suspend", rd_data, 8'hD8);
        wr(0, 8'hD0);
        wait_ready(c);

        // ---- program into the suspended block is rejected
        do_reset();
        wr(6'h20, 8'h20); wr(6'h20, 8'hD0);
        wr(6'h20, 8'hB0);
        wait_ready(c);
        prog(6'h22, 8'h00, 8'h40, c);
        chk(rd_data == 8'hD0, "R10 same-block program rejected", rd_data, 8'hD0);
        rd_arr(6'h22, v);
        chk(v == 8'hFF, "R10 same-block word unchanged", v, 8'hFF);
        wr(0, 8'hD0);
        wait_ready(c);

        // ---- sweep suspend write across the erase (latency vs completion)
        for (int k = 0; k <= E + 1; k++) begin
            bit exp_s;
            do_reset();
            prog(6'h25, 8'h00, 8'h40, c);
            prog(6'h15, 8'h5A, 8'h40, c);
            run_n = 0; sp_n = 0;
            wr(6'h20, 8'h20);
            mon_en = 1'b1;
            wr(6'h20, 8'hD0);
            repeat (k) @(negedge clk);
            wr(6'h20, 8'hB0);
            wait_ready(c);
            exp_s = (k + L + 2 < E);
            chk(rd_data[6] == exp_s, exp_s ? "R8 suspend taken" : "R14 erase beat suspend",
                rd_data, exp_s ? 8'hC0 : 8'h80);
            if (exp_s) begin
                chk(run_n == k + L + 3, "R8 suspend latency", run_n, k + L + 3);
                chk(rd_data == 8'hC0 && !rdy_oe, "R8 suspended status and float",
                    {rdy_oe, rd_data}, 9'h0C0);
                wr(0, 8'hD0);
                chk(rd_data[7:6] == 2'b00 && rdy_oe && !rdy_o, "R11 resume busy",
                    rd_data, 8'h00);
                wait_ready(c);
            end
            mon_en = 1'b0;
            chk(run_n == E + 1, "R11 total erase cycles", run_n, E + 1);
            rd_arr(6'h25, v);
            chk(v == 8'hFF, "R7 erase result after sweep", v, 8'hFF);
            rd_arr(6'h15, v);
            chk(v == 8'h5A, "R7 neighbour block after sweep", v, 8'h5A);
        end

        // ---- sweep resume write across the suspend-time program
        for (int j = 0; j <= P + 2; j++) begin
            do_reset();
            run_n = 0; sp_n = 0;
            wr(6'h20, 8'h20);
            mon_en = 1'b1;
            wr(6'h20, 8'hD0);
            wr(6'h20, 8'hB0);
            wait_ready(c);
            wr(6'h13, 8'h40);
            wr(6'h13, 8'h3C);
            chk(rd_data == 8'h40 && rdy_oe && !rdy_o, "R10 program in suspend status",
                rd_data, 8'h40);
            repeat (j) @(negedge clk);
            wr(0, 8'hD0);
            if (j + 2 <= P)
                chk(rd_data[7:6] == 2'b01, "R12 resume held during program", rd_data, 8'h40);
            while (!(rd_data[7] && !rd_data[6])) @(negedge clk);
            mon_en = 1'b0;
            chk(sp_n == P + 1, "R12 suspend program length", sp_n, P + 1);
            chk(run_n == E + 1, "R12 erase completes after resume", run_n, E + 1);
            chk(rd_data == 8'h80, "R11 bits 6 and 7 after resume", rd_data, 8'h80);
            rd_arr(6'h13, v);
            chk(v == 8'h3C, "R10 suspend program result", v, 8'h3C);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule